// File: doc/BRIEF.md
# Instruction Fetch Protection Exception Unit

This unit decides, for every instruction fetch made while address translation is on, whether the fetch may execute. The decision combines the privilege state taken from the current machine state word, the 2-bit zone code that applies to the page, and the page's execute-permit and guarded flags. In user state a zone code can deny a page outright or grant execution that the page flag alone would deny. In supervisor state the zone code can only grant.

When a fetch is denied, the unit enters the exception in one step. It captures the faulting effective address and the whole machine state word into the save/restore registers. It produces the new machine state word and the new syndrome word, and it raises a one-cycle redirect strobe. The redirect target is built from the vector prefix, followed by the fixed instruction-protection offset. The surrounding core writes the new state and syndrome words when the strobe is high and flushes its pipeline. Page lookup and flush handling are not part of this unit.

Top module: `fetch_prot_unit`

## Requirements
- R1: When `xlateOn` is 0, no fetch raises an exception, whatever the zone, execute and guarded inputs are.
- R2: In user state (`msrCur` bit 14 = 1), a fetch faults if `zoneCode` is 2'b00, or if `pageExec` is 0 and `zoneCode` is not 2'b11. Zone 2'b11 grants execution even when `pageExec` is 0.
- R3: In supervisor state (`msrCur` bit 14 = 0), a fetch faults only if `pageExec` is 0 and `zoneCode` is 2'b00 or 2'b01. Zone 2'b10 or 2'b11 grants execution even when `pageExec` is 0.
- R4: A fetch from a guarded page (`pageGuard` = 1) faults in both privilege states, whatever the zone and execute inputs are.
- R5: On a fault, `srr0` takes the fetch's effective address and `srr1` takes the complete `msrCur` value seen with that fetch.
- R6: On a fault, `excPc` is `{vecPrefix, 16'h0400}`.
- R7: On a fault, `msrNew` keeps only the bits at positions 17, 12 and 9 of `msrCur`. Every other bit is 0, including the bits at positions 18, 15, 14, 10, 5 and 4.
- R8: On a fault, `esrNew` bit 23 is 1 exactly when the fetch was in user state with `zoneCode` 2'b00. This holds even if the page is also guarded. The bit is 0 for faults caused by the execute flag or the guarded flag.
- R9: On a fault, `esrNew` bit 31 equals `esrMciCur`, and every `esrNew` bit other than 31 and 23 is 0.
- R10: `excTake` is high for exactly the one cycle after the edge that samples a faulting fetch with `fetchValid` high. Fetches that do not fault, and cycles with `fetchValid` low, leave `srr0`, `srr1`, `msrNew`, `esrNew` and `excPc` unchanged.
- R11: A synchronous reset sets `excTake`, `srr0`, `srr1` and `esrNew` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchEa | input | 32 | Effective address of the fetch |
| xlateOn | input | 1 | Instruction translation is active |
| msrCur | input | 32 | Current machine state word; bit 14 is the user-state flag |
| zoneCode | input | 2 | Zone protection code for the page |
| pageExec | input | 1 | Page execute-permit flag |
| pageGuard | input | 1 | Page guarded flag |
| vecPrefix | input | 16 | Upper half of the exception vector base |
| esrMciCur | input | 1 | Current machine-check flag in the syndrome word |
| excTake | output | 1 | One-cycle exception-entry and redirect strobe |
| excPc | output | 32 | Redirect target |
| srr0 | output | 32 | Saved faulting address |
| srr1 | output | 32 | Saved machine state word |
| msrNew | output | 32 | Machine state word to write on entry |
| esrNew | output | 32 | Syndrome word to write on entry |

## Verification
The permission logic is tried with every combination of zone code, execute flag and guarded flag, in both privilege states, with translation on. This separates the user-state zone-deny and zone-grant cases from the supervisor-state grant codes 2'b10 and 2'b11. The same combinations are repeated with translation off, which shows that the enable gates every cause. Faults that come from a user zone-00 fetch on a guarded page are set against faults from a supervisor guarded page, which shows the syndrome priority. Machine state inputs of all ones and of alternating patterns show which bits survive and that the save registers capture the whole word. Passing fetches and idle cycles between faults show that the captured values stay unchanged.

// File: rtl/fetch_prot_pkg.sv
package fetch_prot_pkg;
  // machine state word bit positions
  localparam int MSR_WAIT  = 18;
  localparam int MSR_CRIT  = 17;
  localparam int MSR_EXTI  = 15;
  localparam int MSR_USER  = 14;
  localparam int MSR_MCHK  = 12;
  localparam int MSR_DBGW  = 10;
  localparam int MSR_DBGE  = 9;
  localparam int MSR_ITRAN = 5;
  localparam int MSR_DTRAN = 4;
  // syndrome word bit positions
  localparam int ESR_MCI   = 31;
  localparam int ESR_ZONE  = 23;

  localparam logic [1:0] ZONE_DENY = 2'b00;
  localparam logic [1:0] ZONE_FULL = 2'b11;

  typedef struct packed {
    logic take;     // fetch denied, enter exception
    logic zoneHit;  // cause is a user-state zone deny
  } excStrobe_t;
endpackage

// File: rtl/fetch_prot_ctrl.sv
module fetch_prot_ctrl
  import fetch_prot_pkg::*;
(
  input  logic       fetchValid,
  input  logic       xlateOn,
  input  logic       userMode,
  input  logic [1:0] zoneCode,
  input  logic       pageExec,
  input  logic       pageGuard,
  output excStrobe_t stb
);
  logic zoneDeny;
  logic userFault;
  logic supFault;

  always_comb begin
    zoneDeny  = (zoneCode == ZONE_DENY);
    // user state: zone 11 lifts a missing execute flag, zone 00 denies outright
    userFault = zoneDeny || (!pageExec && (zoneCode != ZONE_FULL)) || pageGuard;
    // supervisor state: any zone with the upper bit set lifts a missing execute flag
    supFault  = (!pageExec && !zoneCode[1]) || pageGuard;
    stb.take    = fetchValid && xlateOn && (userMode ? userFault : supFault);
    stb.zoneHit = userMode && zoneDeny;
  end
endmodule

// File: rtl/fetch_prot_dp.sv
module fetch_prot_dp
  import fetch_prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int PFX_W  = 16,
  parameter logic [ADDR_W-PFX_W-1:0] VEC_OFF = 'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  excStrobe_t        stb,
  input  logic [ADDR_W-1:0] fetchEa,
  input  logic [REG_W-1:0]  msrCur,
  input  logic [PFX_W-1:0]  vecPrefix,
  input  logic              esrMciCur,
  output logic              excTake,
  output logic [ADDR_W-1:0] excPc,
  output logic [ADDR_W-1:0] srr0,
  output logic [REG_W-1:0]  srr1,
  output logic [REG_W-1:0]  msrNew,
  output logic [REG_W-1:0]  esrNew
);
  localparam logic [REG_W-1:0] MSR_KEEP =
    (REG_W'(1) << MSR_CRIT) | (REG_W'(1) << MSR_MCHK) | (REG_W'(1) << MSR_DBGE);

  logic [REG_W-1:0] esrNext;

  always_comb begin
    esrNext           = '0;
    esrNext[ESR_MCI]  = esrMciCur;
    esrNext[ESR_ZONE] = stb.zoneHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      excTake <= 1'b0;
      srr0    <= '0;
      srr1    <= '0;
      esrNew  <= '0;
      msrNew  <= '0;
      excPc   <= '0;
    end else begin
      excTake <= stb.take;
      if (stb.take) begin
        srr0   <= fetchEa;
        srr1   <= msrCur;
        msrNew <= msrCur & MSR_KEEP;
        esrNew <= esrNext;
        excPc  <= {vecPrefix, VEC_OFF};
      end
    end
  end
endmodule

// File: rtl/fetch_prot_unit.sv
module fetch_prot_unit
  import fetch_prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int PFX_W  = 16,
  parameter logic [ADDR_W-PFX_W-1:0] VEC_OFF = 'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchEa,
  input  logic              xlateOn,
  input  logic [REG_W-1:0]  msrCur,
  input  logic [1:0]        zoneCode,
  input  logic              pageExec,
  input  logic              pageGuard,
  input  logic [PFX_W-1:0]  vecPrefix,
  input  logic              esrMciCur,
  output logic              excTake,
  output logic [ADDR_W-1:0] excPc,
  output logic [ADDR_W-1:0] srr0,
  output logic [REG_W-1:0]  srr1,
  output logic [REG_W-1:0]  msrNew,
  output logic [REG_W-1:0]  esrNew
);
  excStrobe_t stb;

  fetch_prot_ctrl uCtrl (
    .fetchValid (fetchValid),
    .xlateOn    (xlateOn),
    .userMode   (msrCur[MSR_USER]),
    .zoneCode   (zoneCode),
    .pageExec   (pageExec),
    .pageGuard  (pageGuard),
    .stb        (stb)
  );

  fetch_prot_dp #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .PFX_W  (PFX_W),
    .VEC_OFF(VEC_OFF)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .fetchEa   (fetchEa),
    .msrCur    (msrCur),
    .vecPrefix (vecPrefix),
    .esrMciCur (esrMciCur),
    .excTake   (excTake),
    .excPc     (excPc),
    .srr0      (srr0),
    .srr1      (srr1),
    .msrNew    (msrNew),
    .esrNew    (esrNew)
  );
endmodule

// File: rtl/fetch_prot_chk.sv
module fetch_prot_chk
  import fetch_prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int PFX_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchEa,
  input logic              xlateOn,
  input logic [REG_W-1:0]  msrCur,
  input logic [1:0]        zoneCode,
  input logic              pageGuard,
  input logic              excTake,
  input logic [ADDR_W-1:0] excPc,
  input logic [ADDR_W-1:0] srr0,
  input logic [REG_W-1:0]  msrNew,
  input logic [REG_W-1:0]  esrNew
);
  AST_NO_XLATE_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && !xlateOn) |=> !excTake);  // R1

  AST_GUARD_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && xlateOn && pageGuard) |=> excTake);  // R4

  AST_SRR0_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && xlateOn && pageGuard) |=> (srr0 == $past(fetchEa)));  // R5

  AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    excTake |-> (excPc[ADDR_W-PFX_W-1:0] == 'h0400));  // R6

  AST_MSR_PRIV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    excTake |-> (!msrNew[MSR_USER] && !msrNew[MSR_ITRAN] && !msrNew[MSR_DTRAN]));  // R7

  AST_SUP_NO_ZONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && xlateOn && !msrCur[MSR_USER]) |=> (!excTake || !esrNew[ESR_ZONE]));  // R8

  AST_USER_ZONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && xlateOn && msrCur[MSR_USER] && zoneCode == ZONE_DENY)
      |=> (excTake && esrNew[ESR_ZONE]));  // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !fetchValid |=> !excTake);  // R10

  AST_HOLD_SRR0: assert property (@(posedge clk) disable iff (rst)
    !excTake |-> $stable(srr0));  // R10
endmodule

bind fetch_prot_unit fetch_prot_chk #(
  .ADDR_W(ADDR_W),
  .REG_W (REG_W),
  .PFX_W (PFX_W)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .fetchValid(fetchValid),
  .fetchEa   (fetchEa),
  .xlateOn   (xlateOn),
  .msrCur    (msrCur),
  .zoneCode  (zoneCode),
  .pageGuard (pageGuard),
  .excTake   (excTake),
  .excPc     (excPc),
  .srr0      (srr0),
  .msrNew    (msrNew),
  .esrNew    (esrNew)
);

// File: tb/sim_fetch_prot_unit.sv
module sim_fetch_prot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetchValid;
  logic [31:0] fetchEa;
  logic        xlateOn;
  logic [31:0] msrCur;
  logic [1:0]  zoneCode;
  logic        pageExec;
  logic        pageGuard;
  logic [15:0] vecPrefix;
  logic        esrMciCur;
  logic        excTake;
  logic [31:0] excPc, srr0, srr1, msrNew, esrNew;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_prot_unit u0 (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchEa(fetchEa),
    .xlateOn(xlateOn), .msrCur(msrCur), .zoneCode(zoneCode),
    .pageExec(pageExec), .pageGuard(pageGuard), .vecPrefix(vecPrefix),
    .esrMciCur(esrMciCur), .excTake(excTake), .excPc(excPc),
    .srr0(srr0), .srr1(srr1), .msrNew(msrNew), .esrNew(esrNew)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected fault decision, from R1..R4
  function automatic bit expFault(bit xl, bit user, logic [1:0] z, bit ex, bit g);
    if (!xl) return 1'b0;
    if (g) return 1'b1;
    if (user) return (z == 2'b00) || (!ex && z != 2'b11);
    return !ex && (z == 2'b00 || z == 2'b01);
  endfunction

  // present one fetch, sample one cycle later, then check the pulse ends
  task automatic doFetch(input string req, input logic [31:0] ea, input bit xl,
                         input logic [31:0] msr, input logic [1:0] z,
                         input bit ex, input bit g, input logic [15:0] pfx,
                         input bit mci);
    logic [31:0] oSrr0, oSrr1, oMsr, oEsr, oPc;
    bit f;
    bit user;
    logic [31:0] expEsr;
    user = msr[14];
    f = expFault(xl, user, z, ex, g);
    @(negedge clk);
    oSrr0 = srr0; oSrr1 = srr1; oMsr = msrNew; oEsr = esrNew; oPc = excPc;
    fetchValid = 1'b1; fetchEa = ea; xlateOn = xl; msrCur = msr;
    zoneCode = z; pageExec = ex; pageGuard = g; vecPrefix = pfx; esrMciCur = mci;
    @(negedge clk);
    fetchValid = 1'b0;
    check(req, "excTake", {31'b0, excTake}, {31'b0, f});
    if (f) begin
      expEsr = 32'b0;
      expEsr[31] = mci;
      expEsr[23] = user && (z == 2'b00);
      check("R5", "srr0", srr0, ea);
      check("R5", "srr1", srr1, msr);
      check("R6", "excPc", excPc, {pfx, 16'h0400});
      check("R7", "msrNew", msrNew, msr & 32'h0002_1200);
      check("R8/R9", "esrNew", esrNew, expEsr);
    end else begin
      check("R10", "srr0 held", srr0, oSrr0);
      check("R10", "srr1 held", srr1, oSrr1);
      check("R10", "msrNew held", msrNew, oMsr);
      check("R10", "esrNew held", esrNew, oEsr);
      check("R10", "excPc held", excPc, oPc);
    end
    @(negedge clk);
    check("R10", "strobe one cycle", {31'b0, excTake}, 32'b0);
  endtask

  task automatic testReset();
    check("R11", "excTake", {31'b0, excTake}, 32'b0);
    check("R11", "srr0", srr0, 32'b0);
    check("R11", "srr1", srr1, 32'b0);
    check("R11", "esrNew", esrNew, 32'b0);
  endtask

  task automatic testNoXlate();  // R1
    for (int i = 0; i < 16; i++)
      for (int u = 0; u < 2; u++)
        doFetch("R1", 32'h1000_0000 + i, 1'b0, u ? 32'h0000_4000 : 32'h0,
                i[1:0], i[2], i[3], 16'hABCD, 1'b0);
  endtask

  task automatic testUserTable();  // R2, R4
    for (int i = 0; i < 16; i++)
      doFetch(i[3] ? "R4" : "R2", 32'h2000_0040 + (i << 4), 1'b1,
              32'h0000_4000 | (i << 20), i[1:0], i[2], i[3], 16'h0FFF, i[0]);
  endtask

  task automatic testSupTable();  // R3, R4
    for (int i = 0; i < 16; i++)
      doFetch(i[3] ? "R4" : "R3", 32'h3000_0100 + (i << 4), 1'b1,
              32'h0000_0020 | (i << 24), i[1:0], i[2], i[3], 16'hF00D, ~i[0]);
  endtask

  task automatic testMsrAndSyndrome();  // R7, R8, R9
    doFetch("R7", 32'hDEAD_BEEC, 1'b1, 32'hFFFF_FFFF, 2'b01, 1'b0, 1'b0, 16'h1234, 1'b1);
    doFetch("R8", 32'h4444_0000, 1'b1, 32'hAAAA_CAAA, 2'b00, 1'b1, 1'b1, 16'h5555, 1'b0);
    doFetch("R8", 32'h5555_0004, 1'b1, 32'h5555_9555 & ~32'h4000, 2'b00, 1'b1, 1'b1, 16'h7777, 1'b1);
    doFetch("R9", 32'h6666_0008, 1'b1, 32'h0000_4000, 2'b10, 1'b0, 1'b0, 16'h0001, 1'b1);
  endtask

  task automatic testIdleHold();  // R10
    logic [31:0] s0;
    doFetch("R10", 32'h7000_0000, 1'b1, 32'h0000_4000, 2'b00, 1'b1, 1'b0, 16'h2222, 1'b0);
    s0 = srr0;
    @(negedge clk);
    fetchEa = 32'hFFFF_0000; xlateOn = 1'b1; msrCur = 32'h0000_4000;
    zoneCode = 2'b00; pageGuard = 1'b1; fetchValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "idle excTake", {31'b0, excTake}, 32'b0);
    check("R10", "idle srr0 held", srr0, s0);
  endtask

  initial begin
    rst = 1'b1; fetchValid = 1'b0; fetchEa = '0; xlateOn = 1'b0; msrCur = '0;
    zoneCode = '0; pageExec = 1'b0; pageGuard = 1'b0; vecPrefix = '0; esrMciCur = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    rst = 1'b0;
    testNoXlate();
    testUserTable();
    testSupTable();
    testMsrAndSyndrome();
    testIdleHold();
    // reset after faults clears state again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    testReset();
    rst = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule